// File: doc/BRIEF.md
# Host Configuration Control Register

This block is a firmware-owned control and status byte with a 16-bit host configuration base address next to it. Firmware uses one control bit to hold the host in soft reset through an active-low output. Writing the high address byte marks the stored address as valid. A set-only lock freezes the valid flag and both address bytes. Only a cold reset (power-up or watchdog) releases the lock; a warm host reset leaves it in place. A second control bit enables a power-off event so that it reaches the interrupt and wake-up logic.

When a plug-and-play configuration sequence starts, the block takes a snapshot of the base address and the valid flag. It presents that snapshot until the sequence ends, so firmware writes made during the sequence do not disturb it. An address that was not valid when the snapshot was taken is never presented.

Top module: `hcfg_ctrl`

## Requirements
- R1: After a cold reset, `ctl_q` is 0x00, `host_rst_n` is 1, `pwroff_out` is 0, `base_q` is 0 and the plug-and-play outputs are 0. After a warm reset, bits 0, 1 and 3 of `ctl_q` read 0.
- R2: Bit 0 of the control byte (`wr_sel` = 0) is written directly. `host_rst_n` is low in every cycle after the write edge while bit 0 is 1, and high while it is 0.
- R3: Any write to the high address byte (`wr_sel` = 2) while unlocked sets the valid flag (bit 1) from the next cycle. A write to the low byte (`wr_sel` = 1) does not change it.
- R4: Writing 1 to bit 1 of the control byte clears the valid flag. Writing 0 to it leaves the flag unchanged.
- R5: Writing 1 to bit 2 sets the lock. Firmware writes cannot clear it.
- R6: While the lock is 1, writes to either address byte and writes to bit 1 are discarded.
- R7: A cold reset clears the lock. A warm reset keeps the lock and the address bytes.
- R8: Bit 3 is an event enable. `pwroff_out` equals `pwroff_evt` one cycle late when the enable was 1, and is 0 when it was 0.
- R9: At `pnp_start` (with no sequence active) the base address and the valid flag held before that edge are captured. `pnp_addr` shows the captured address from the next cycle until `pnp_end`, whatever is written to the address bytes in between.
- R10: If the captured valid flag is 0, `pnp_addr_ok` is 0 and `pnp_addr` is 0 for the whole sequence. `pnp_addr_ok` and `pnp_addr` are 0 outside a sequence.
- R11: Bits 7 to 4 of the control byte read 0, and writing them has no effect.
- R12: A `pnp_start` while a sequence is active is ignored. `pnp_end` ends the sequence, and the outputs read 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous power-up or watchdog reset, active high |
| warm_rst | input | 1 | Synchronous warm host reset, active high |
| wr_en | input | 1 | Firmware write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 address low, 2 address high |
| wr_data | input | 8 | Write data |
| ctl_q | output | 8 | Control byte readback |
| base_q | output | 16 | Stored configuration base address |
| host_rst_n | output | 1 | Host soft reset, active low |
| pwroff_evt | input | 1 | Power-off event from the clock or power block |
| pwroff_out | output | 1 | Gated power-off event to the interrupt and wake-up logic |
| pnp_start | input | 1 | Plug-and-play sequence start strobe |
| pnp_end | input | 1 | Plug-and-play sequence end strobe |
| pnp_addr | output | 16 | Address in effect for the current sequence |
| pnp_addr_ok | output | 1 | The address in effect is valid |

## Verification
The bench puts a warm reset on a locked register. A design that treats both resets alike would unlock there and accept new address writes. Several cases combine writes in one step, such as a lock written together with a valid clear, or a high-byte write after locking. A design that checks the new lock value instead of the old one would keep a flag that should have cleared, or the reverse. During an open sequence the bench rewrites the address and strobes start again. A design that samples on every start or passes the live address through would show the new value. A sequence started while the address is invalid must present zero, so a design that forgets the captured flag would leak the address.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;
  localparam int unsigned BIT_HRST  = 0;
  localparam int unsigned BIT_VALID = 1;
  localparam int unsigned BIT_LOCK  = 2;
  localparam int unsigned BIT_EVTEN = 3;
  localparam int unsigned CTL_BITS  = 4;
endpackage

// File: rtl/hcfg_ctl_reg.sv
module hcfg_ctl_reg
  import hcfg_pkg::*;
(
  input  logic                clk,
  input  logic                cold_rst,
  input  logic                warm_rst,
  input  logic                ctl_we,
  input  logic [CTL_BITS-1:0] ctl_wd,
  input  logic                hi_we,
  output logic                rst_bit,
  output logic                valid,
  output logic                lock,
  output logic                evt_en
);

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      rst_bit <= 1'b0;
      valid   <= 1'b0;
      lock    <= 1'b0;
      evt_en  <= 1'b0;
    end else if (warm_rst) begin
      rst_bit <= 1'b0;
      valid   <= 1'b0;
      evt_en  <= 1'b0;
    end else begin
      if (ctl_we) begin
        rst_bit <= ctl_wd[BIT_HRST];
        evt_en  <= ctl_wd[BIT_EVTEN];
        if (ctl_wd[BIT_LOCK]) lock <= 1'b1;
        if (ctl_wd[BIT_VALID] && !lock) valid <= 1'b0;
      end
      if (hi_we && !lock) valid <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (cold_rst)
    lock |=> lock); // R5
  AST_VALID_FROZEN: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    lock |=> $stable(valid)); // R6
  AST_HI_SETS_VALID: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    (hi_we && !lock) |=> valid); // R3

endmodule

// File: rtl/hcfg_base_reg.sv
module hcfg_base_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wd,
  input  logic              lock,
  output logic [ADDR_W-1:0] base,
  output logic              hi_we
);
  localparam int NBYTES = ADDR_W / DATA_W;
  localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(NBYTES);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g + 1);
    always_ff @(posedge clk) begin
      if (cold_rst)
        base[g*DATA_W +: DATA_W] <= '0;
      else if (we && !lock && sel == MY_SEL)
        base[g*DATA_W +: DATA_W] <= wd;
    end
  end

  assign hi_we = we && (sel == HI_SEL);

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (cold_rst)
    lock |=> $stable(base)); // R6

endmodule

// File: rtl/hcfg_pnp_snap.sv
module hcfg_pnp_snap #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [ADDR_W-1:0] base,
  input  logic              valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              eff_ok
);
  logic              active;
  logic              snap_ok;
  logic [ADDR_W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      snap_ok <= 1'b0;
      snap    <= '0;
    end else if (active) begin
      if (stop) active <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      snap    <= base;
      snap_ok <= valid;
    end
  end

  assign eff_ok   = active && snap_ok;
  assign eff_addr = eff_ok ? snap : '0;

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (active && !stop) |=> $stable(eff_addr)); // R9
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (active && start && !stop) |=> $stable(eff_ok)); // R12

endmodule

// File: rtl/hcfg_ctrl.sv
module hcfg_ctrl
  import hcfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      cold_rst,
  input  logic                      warm_rst,
  input  logic                      wr_en,
  input  logic [$clog2(ADDR_W/DATA_W+1)-1:0] wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         ctl_q,
  output logic [ADDR_W-1:0]         base_q,
  output logic                      host_rst_n,
  input  logic                      pwroff_evt,
  output logic                      pwroff_out,
  input  logic                      pnp_start,
  input  logic                      pnp_end,
  output logic [ADDR_W-1:0]         pnp_addr,
  output logic                      pnp_addr_ok
);
  localparam int NBYTES = ADDR_W / DATA_W;
  localparam int SEL_W  = $clog2(NBYTES + 1);

  logic rst_bit, valid, lock, evt_en, hi_we, ctl_we;

  assign ctl_we = wr_en && (wr_sel == '0);

  hcfg_ctl_reg u_ctl (
    .clk      (clk),
    .cold_rst (cold_rst),
    .warm_rst (warm_rst),
    .ctl_we   (ctl_we),
    .ctl_wd   (wr_data[CTL_BITS-1:0]),
    .hi_we    (hi_we),
    .rst_bit  (rst_bit),
    .valid    (valid),
    .lock     (lock),
    .evt_en   (evt_en)
  );

  hcfg_base_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_base (
    .clk      (clk),
    .cold_rst (cold_rst),
    .we       (wr_en),
    .sel      (wr_sel),
    .wd       (wr_data),
    .lock     (lock),
    .base     (base_q),
    .hi_we    (hi_we)
  );

  hcfg_pnp_snap #(.ADDR_W(ADDR_W)) u_snap (
    .clk      (clk),
    .rst      (cold_rst || warm_rst),
    .start    (pnp_start),
    .stop     (pnp_end),
    .base     (base_q),
    .valid    (valid),
    .eff_addr (pnp_addr),
    .eff_ok   (pnp_addr_ok)
  );

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) pwroff_out <= 1'b0;
    else                      pwroff_out <= pwroff_evt && evt_en;
  end

  always_comb begin
    ctl_q            = '0;
    ctl_q[BIT_HRST]  = rst_bit;
    ctl_q[BIT_VALID] = valid;
    ctl_q[BIT_LOCK]  = lock;
    ctl_q[BIT_EVTEN] = evt_en;
  end

  assign host_rst_n = !rst_bit;

  AST_EVT_BLOCKED: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    !evt_en |=> !pwroff_out); // R8

endmodule

// File: tb/sim_hcfg_ctrl.sv
`timescale 1ns/1ps
module sim_hcfg_ctrl;
  logic        clk = 1'b0;
  logic        cold_rst = 1'b1, warm_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  ctl_q;
  logic [15:0] base_q, pnp_addr;
  logic        host_rst_n, pwroff_out, pnp_addr_ok;
  logic        pwroff_evt = 1'b0, pnp_start = 1'b0, pnp_end = 1'b0;

  hcfg_ctrl u0 (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ctl_q(ctl_q), .base_q(base_q),
    .host_rst_n(host_rst_n), .pwroff_evt(pwroff_evt), .pwroff_out(pwroff_out),
    .pnp_start(pnp_start), .pnp_end(pnp_end), .pnp_addr(pnp_addr),
    .pnp_addr_ok(pnp_addr_ok)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit        m_rstb, m_valid, m_lock, m_en, m_pwr, m_act, m_ok;
  bit [15:0] m_base, m_snap;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    bit old_lock = m_lock, old_valid = m_valid;
    bit [15:0] old_base = m_base;
    if (cold_rst) begin
      {m_rstb, m_valid, m_lock, m_en, m_pwr, m_act, m_ok} = '0;
      m_base = 0; m_snap = 0;
    end else if (warm_rst) begin
      {m_rstb, m_valid, m_en, m_pwr, m_act, m_ok} = '0;
      m_snap = 0;
    end else begin
      m_pwr = pwroff_evt && m_en;
      if (m_act) begin
        if (pnp_end) m_act = 0;
      end else if (pnp_start) begin
        m_act = 1; m_snap = old_base; m_ok = old_valid;
      end
      if (wr_en && wr_sel == 2'd0) begin
        m_rstb = wr_data[0];
        m_en   = wr_data[3];
        if (wr_data[2]) m_lock = 1;
        if (wr_data[1] && !old_lock) m_valid = 0;
      end
      if (wr_en && wr_sel == 2'd1 && !old_lock) m_base[7:0] = wr_data;
      if (wr_en && wr_sel == 2'd2 && !old_lock) begin
        m_base[15:8] = wr_data; m_valid = 1;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    chk("ctl_q", ctl_q, {4'b0, m_en, m_lock, m_valid, m_rstb});
    chk("base_q", base_q, m_base);
    chk("host_rst_n", host_rst_n, !m_rstb);
    chk("pwroff_out", pwroff_out, m_pwr);
    chk("pnp_addr", pnp_addr, (m_act && m_ok) ? m_snap : 16'h0);
    chk("pnp_addr_ok", pnp_addr_ok, m_act && m_ok);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    cur_req = "R1"; tick(); tick();
    cold_rst = 0; tick();

    cur_req = "R2"; wr(2'd0, 8'h01); tick(); wr(2'd0, 8'h00);

    cur_req = "R3"; wr(2'd1, 8'h34); wr(2'd2, 8'h12); tick();

    cur_req = "R4"; wr(2'd0, 8'h00); wr(2'd0, 8'h02); wr(2'd2, 8'h56);

    cur_req = "R11"; wr(2'd0, 8'hF8);
    cur_req = "R8";
    pwroff_evt = 1; tick(); pwroff_evt = 0; tick();
    wr(2'd0, 8'h00);
    pwroff_evt = 1; tick(); tick(); pwroff_evt = 0; tick();

    cur_req = "R9";
    pnp_start = 1; tick(); pnp_start = 0;
    wr(2'd1, 8'hAA); wr(2'd2, 8'hBB); tick();
    cur_req = "R12";
    pnp_start = 1; tick(); pnp_start = 0; tick();
    pnp_end = 1; tick(); pnp_end = 0; tick();

    cur_req = "R10";
    wr(2'd0, 8'h02);
    pnp_start = 1; tick(); pnp_start = 0; tick();
    pnp_end = 1; tick(); pnp_end = 0;

    cur_req = "R5";
    wr(2'd2, 8'h77); wr(2'd0, 8'h04); wr(2'd0, 8'h00); tick();
    cur_req = "R6";
    wr(2'd0, 8'h02); wr(2'd1, 8'h11); wr(2'd2, 8'h22); tick();

    cur_req = "R7";
    warm_rst = 1; tick(); warm_rst = 0; tick();
    wr(2'd2, 8'h99); tick();
    cold_rst = 1; tick(); cold_rst = 0; tick();
    wr(2'd2, 8'h99);

    cur_req = "mix";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        wr_en      = lf[0];
        wr_sel     = lf[2:1];
        wr_data    = lf[10:3];
        pwroff_evt = lf[5];
        pnp_start  = lf[11] & lf[12];
        pnp_end    = lf[13] & lf[14] & lf[15];
        warm_rst   = (lf[15:11] == 5'd3);
        cold_rst   = (lf[15:10] == 6'd9);
        tick();
      end
      {wr_en, pwroff_evt, pnp_start, pnp_end, warm_rst, cold_rst} = '0;
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule